// File: doc/BRIEF.md
# Opcode Byte Class Decoder

This block sorts one instruction opcode byte into a small set of instruction classes. It does this once the legacy prefixes have been gathered and before the operands are looked at. With each byte it takes the opcode map the byte belongs to, the prefixes already seen and, when one is available, the ModRM byte that follows. It returns a class code. For the short register forms it also returns the register number held in the opcode. For the condition-code families it returns the 4-bit condition. A last flag says that the class cannot be settled until a ModRM byte is supplied.

The byte is not looked up in one flat table. It is split by family. The register-in-opcode forms use bits 7:3 as the family and bits 2:0 as the register. The condition families use the high nibble as the family and the low nibble as the condition. The extension group at 0xFF takes three more opcode bits from ModRM bits 5:3. Opcode 0x90 in the one-byte map becomes a different class depending on which prefixes are present. Each opcode map has its own decoder, and the map input selects which result is used.

The input and output are valid/ready streams with one register stage between them. The input is accepted on any clock edge where `in_valid` and `in_ready` are both high. The result then appears with `out_valid` on the next edge. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low. When the stage is empty, or is being drained in the same cycle, `in_ready` is high. This lets the block accept a new byte in every cycle while the consumer keeps up.

Top module: `opc_class_decoder`

## Requirements
- R1: While reset is held and immediately after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: In the one-byte map (`in_map` = 0), bytes 0x50 to 0x57 give class 1 (push register), and `out_reg` equals opcode bits 2:0.
- R3: In the one-byte map, bytes 0x58 to 0x5F give class 2 (pop register), and `out_reg` equals opcode bits 2:0.
- R4: In the one-byte map, bytes 0x70 to 0x7F give class 3 (short conditional jump), and `out_cond` equals the low nibble of the opcode.
- R5: In the 0F map (`in_map` = 1), the low nibble of the opcode is returned on `out_cond` for three ranges. Bytes 0x40 to 0x4F give class 4 (conditional move). Bytes 0x80 to 0x8F give class 5 (near conditional jump). Bytes 0x90 to 0x9F give class 6 (set on condition).
- R6: Byte 0x90 in the one-byte map is classed by its prefixes. With no prefix it is class 7 (nop). When `in_prefix` bit 0 (operand-size, 0x66) is set and bit 1 is clear, it is class 8 (two-byte nop). When `in_prefix` bit 1 (0xF3) is set it is class 9 (pause), whatever the other bits are. Bit 2 (0xF2) has no effect.
- R7: Byte 0xFF in the one-byte map with `in_modrm_valid` low gives class 16 (ModRM needed) and sets `out_need_modrm`. For every other input, `out_need_modrm` is 0.
- R8: Byte 0xFF in the one-byte map with `in_modrm_valid` high is classed by ModRM bits 5:3. A value of 0 gives class 10 (increment). 1 gives class 11 (decrement). 2 gives class 12 (indirect near call). 4 gives class 13 (indirect near jump). 6 gives class 14 (push memory/register). 7 gives class 15 (invalid). 3 and 5 give class 0.
- R9: Any byte not listed above, and every byte in the 0F 38 and 0F 3A maps (`in_map` = 2 and 3), gives class 0 (other). `out_reg` and `out_cond` are 0 for every class that does not define them, and the prefixes and the ModRM byte change nothing except where R6 and R8 say so.
- R10: A result appears on the output one edge after its byte is accepted. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A result is held stable while `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block can take an input this cycle |
| in_opcode | input | 8 | Opcode byte |
| in_map | input | 2 | Opcode map: 0 one-byte, 1 0F, 2 0F 38, 3 0F 3A |
| in_prefix | input | 3 | Seen prefixes: bit 0 is 0x66, bit 1 is 0xF3, bit 2 is 0xF2 |
| in_modrm_valid | input | 1 | `in_modrm` holds the following ModRM byte |
| in_modrm | input | 8 | ModRM byte |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_class | output | 5 | Instruction class code |
| out_reg | output | 3 | Register number held in the opcode |
| out_cond | output | 4 | Condition code held in the opcode |
| out_need_modrm | output | 1 | Class depends on a ModRM byte that was not supplied |

## Verification
A wrong entry in one of the map decoders shows as a wrong class, register or condition on the first result from the affected byte range. It appears one edge after that byte is accepted, so a full sweep of every byte in every map exposes it within a few thousand cycles. A fault in the output register or the ready logic shows as a changed result during a stall, or as a lost or duplicated result. The model checks `out_valid` and `in_ready` on every clock under random back-pressure, so such a fault is reported in the first cycle it occurs.

// File: rtl/opc_pkg.sv
package opc_pkg;

  localparam int OPC_W  = 8;
  localparam int REG_W  = 3;
  localparam int COND_W = 4;
  localparam int MAP_W  = 2;
  localparam int PFX_W  = 3;
  localparam int CLS_W  = 5;
  localparam int N_MAPS = 1 << MAP_W;

  localparam int FAM5_W = OPC_W - REG_W;
  localparam int FAM4_W = OPC_W - COND_W;

  localparam int PFX_OPSIZE = 0;
  localparam int PFX_REP    = 1;
  localparam int PFX_REPNE  = 2;

  localparam int MODRM_REG_LO = 3;

  localparam logic [FAM5_W-1:0] FAM_PUSH_REG = 5'b01010;
  localparam logic [FAM5_W-1:0] FAM_POP_REG  = 5'b01011;
  localparam logic [FAM4_W-1:0] FAM_JCC_SHORT = 4'h7;
  localparam logic [FAM4_W-1:0] FAM_CMOV      = 4'h4;
  localparam logic [FAM4_W-1:0] FAM_JCC_NEAR  = 4'h8;
  localparam logic [FAM4_W-1:0] FAM_SETCC     = 4'h9;
  localparam logic [OPC_W-1:0]  BYTE_XCHG_NOP = 8'h90;
  localparam logic [OPC_W-1:0]  BYTE_GRP_FF   = 8'hFF;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER      = 5'd0,
    CLS_PUSH_REG   = 5'd1,
    CLS_POP_REG    = 5'd2,
    CLS_JCC_SHORT  = 5'd3,
    CLS_CMOVCC     = 5'd4,
    CLS_JCC_NEAR   = 5'd5,
    CLS_SETCC      = 5'd6,
    CLS_NOP        = 5'd7,
    CLS_NOP2       = 5'd8,
    CLS_PAUSE      = 5'd9,
    CLS_INC_RM     = 5'd10,
    CLS_DEC_RM     = 5'd11,
    CLS_CALL_IND   = 5'd12,
    CLS_JMP_IND    = 5'd13,
    CLS_PUSH_RM    = 5'd14,
    CLS_INVALID    = 5'd15,
    CLS_NEED_MODRM = 5'd16
  } opc_class_e;

  typedef enum logic [MAP_W-1:0] {
    MAP_ONE  = 2'd0,
    MAP_0F   = 2'd1,
    MAP_0F38 = 2'd2,
    MAP_0F3A = 2'd3
  } opc_map_e;

  typedef struct packed {
    opc_class_e               cls;
    logic [REG_W-1:0]         reg_idx;
    logic [COND_W-1:0]        cond;
    logic                     need_modrm;
  } opc_result_t;

  localparam int RES_W = $bits(opc_result_t);

  localparam opc_result_t RES_NONE = '{cls: CLS_OTHER, reg_idx: '0, cond: '0, need_modrm: 1'b0};

  function automatic logic in_fam5(input logic [OPC_W-1:0] op, input logic [FAM5_W-1:0] fam);
    return op[OPC_W-1:REG_W] == fam;
  endfunction

  function automatic logic in_fam4(input logic [OPC_W-1:0] op, input logic [FAM4_W-1:0] fam);
    return op[OPC_W-1:COND_W] == fam;
  endfunction

endpackage

// File: rtl/opc_grp_ext_dec.sv
module opc_grp_ext_dec
  import opc_pkg::*;
(
  input  logic             modrm_valid,
  input  logic [REG_W-1:0] modrm_reg,
  output opc_result_t      res
);

  always_comb begin
    res = RES_NONE;
    if (!modrm_valid) begin
      res.cls        = CLS_NEED_MODRM;
      res.need_modrm = 1'b1;
    end else begin
      unique case (modrm_reg)
        3'd0:    res.cls = CLS_INC_RM;
        3'd1:    res.cls = CLS_DEC_RM;
        3'd2:    res.cls = CLS_CALL_IND;
        3'd4:    res.cls = CLS_JMP_IND;
        3'd6:    res.cls = CLS_PUSH_RM;
        3'd7:    res.cls = CLS_INVALID;
        default: res.cls = CLS_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/opc_map_one_dec.sv
module opc_map_one_dec
  import opc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             pfx_opsize,
  input  logic             pfx_rep,
  input  opc_result_t      grp_res,
  output opc_result_t      res
);

  always_comb begin
    res = RES_NONE;
    if (in_fam5(opcode, FAM_PUSH_REG)) begin
      res.cls     = CLS_PUSH_REG;
      res.reg_idx = opcode[REG_W-1:0];
    end else if (in_fam5(opcode, FAM_POP_REG)) begin
      res.cls     = CLS_POP_REG;
      res.reg_idx = opcode[REG_W-1:0];
    end else if (in_fam4(opcode, FAM_JCC_SHORT)) begin
      res.cls  = CLS_JCC_SHORT;
      res.cond = opcode[COND_W-1:0];
    end else if (opcode == BYTE_XCHG_NOP) begin
      if (pfx_rep)         res.cls = CLS_PAUSE;
      else if (pfx_opsize) res.cls = CLS_NOP2;
      else                 res.cls = CLS_NOP;
    end else if (opcode == BYTE_GRP_FF) begin
      res = grp_res;
    end
  end

endmodule

// File: rtl/opc_map_0f_dec.sv
module opc_map_0f_dec
  import opc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output opc_result_t      res
);

  always_comb begin
    res = RES_NONE;
    if (in_fam4(opcode, FAM_CMOV)) begin
      res.cls  = CLS_CMOVCC;
      res.cond = opcode[COND_W-1:0];
    end else if (in_fam4(opcode, FAM_JCC_NEAR)) begin
      res.cls  = CLS_JCC_NEAR;
      res.cond = opcode[COND_W-1:0];
    end else if (in_fam4(opcode, FAM_SETCC)) begin
      res.cls  = CLS_SETCC;
      res.cond = opcode[COND_W-1:0];
    end
  end

endmodule

// File: rtl/opc_out_stage.sv
module opc_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/opc_class_decoder.sv
module opc_class_decoder
  import opc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [MAP_W-1:0]  in_map,
  input  logic [PFX_W-1:0]  in_prefix,
  input  logic              in_modrm_valid,
  input  logic [OPC_W-1:0]  in_modrm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CLS_W-1:0]  out_class,
  output logic [REG_W-1:0]  out_reg,
  output logic [COND_W-1:0] out_cond,
  output logic              out_need_modrm
);

  opc_result_t grp_res;
  opc_result_t map_res [N_MAPS];
  opc_result_t sel_res;
  opc_result_t held_res;
  logic [RES_W-1:0] held_bits;

  logic unused_inputs;
  assign unused_inputs = ^{in_prefix[PFX_REPNE],
                           in_modrm[OPC_W-1:MODRM_REG_LO+REG_W],
                           in_modrm[MODRM_REG_LO-1:0]};

  opc_grp_ext_dec u_grp (
    .modrm_valid (in_modrm_valid),
    .modrm_reg   (in_modrm[MODRM_REG_LO +: REG_W]),
    .res         (grp_res)
  );

  for (genvar m = 0; m < N_MAPS; m++) begin : g_map
    if (m == int'(MAP_ONE)) begin : g_one
      opc_map_one_dec u_dec (
        .opcode     (in_opcode),
        .pfx_opsize (in_prefix[PFX_OPSIZE]),
        .pfx_rep    (in_prefix[PFX_REP]),
        .grp_res    (grp_res),
        .res        (map_res[m])
      );
    end else if (m == int'(MAP_0F)) begin : g_0f
      opc_map_0f_dec u_dec (
        .opcode (in_opcode),
        .res    (map_res[m])
      );
    end else begin : g_wide
      assign map_res[m] = RES_NONE;
    end
  end

  assign sel_res = map_res[in_map];

  opc_out_stage #(.W(RES_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (sel_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held_bits)
  );

  assign held_res       = opc_result_t'(held_bits);
  assign out_class      = held_res.cls;
  assign out_reg        = held_res.reg_idx;
  assign out_cond       = held_res.cond;
  assign out_need_modrm = held_res.need_modrm;

endmodule

// File: rtl/opc_class_decoder_chk.sv
module opc_class_decoder_chk
  import opc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OPC_W-1:0]  in_opcode,
  input logic [MAP_W-1:0]  in_map,
  input logic [PFX_W-1:0]  in_prefix,
  input logic              in_modrm_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CLS_W-1:0]  out_class,
  input logic [REG_W-1:0]  out_reg,
  input logic [COND_W-1:0] out_cond,
  input logic              out_need_modrm
);

  logic acc_one;
  assign acc_one = in_valid && in_ready && (in_map == MAP_ONE);

  assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_reg)
                                && $stable(out_cond) && $stable(out_need_modrm));

  assert_push_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_one && in_opcode[7:3] == 5'b01010 |=>
      out_valid && out_class == CLS_PUSH_REG && out_reg == $past(in_opcode[2:0]));

  assert_pop_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_one && in_opcode[7:3] == 5'b01011 |=>
      out_valid && out_class == CLS_POP_REG && out_reg == $past(in_opcode[2:0]));

  assert_short_jcc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_one && in_opcode[7:4] == 4'h7 |=>
      out_class == CLS_JCC_SHORT && out_cond == $past(in_opcode[3:0]));

  assert_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_one && in_opcode == 8'h90 && in_prefix[1] |=> out_class == CLS_PAUSE);

  assert_need_modrm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_one && in_opcode == 8'hFF && !in_modrm_valid |=> out_need_modrm);

  assert_wide_maps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_map[1] |=> out_class == CLS_OTHER && !out_need_modrm);

endmodule

bind opc_class_decoder opc_class_decoder_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_opcode      (in_opcode),
  .in_map         (in_map),
  .in_prefix      (in_prefix),
  .in_modrm_valid (in_modrm_valid),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_class      (out_class),
  .out_reg        (out_reg),
  .out_cond       (out_cond),
  .out_need_modrm (out_need_modrm)
);

// File: tb/opc_class_decoder_test.sv
module opc_class_decoder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_opcode = '0;
  logic [1:0] in_map = '0;
  logic [2:0] in_prefix = '0;
  logic       in_modrm_valid = 1'b0;
  logic [7:0] in_modrm = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [4:0] out_class;
  logic [2:0] out_reg;
  logic [3:0] out_cond;
  logic       out_need_modrm;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit bp_on = 0;

  always #5 clk = ~clk;

  opc_class_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_map(in_map), .in_prefix(in_prefix),
    .in_modrm_valid(in_modrm_valid), .in_modrm(in_modrm),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
    .out_reg(out_reg), .out_cond(out_cond), .out_need_modrm(out_need_modrm)
  );

  // Behavioural expectation from the requirements
  task automatic expect_of(input int mp, input int op, input int pf, input bit mv,
                           input int mr, output int cls, output int rg,
                           output int cc, output int nm, output string rq);
    int r;
    cls = 0; rg = 0; cc = 0; nm = 0; rq = "R9";
    r = (mr / 8) % 8;
    if (mp == 0) begin
      if (op >= 'h50 && op <= 'h57) begin cls = 1; rg = op - 'h50; rq = "R2"; end
      else if (op >= 'h58 && op <= 'h5F) begin cls = 2; rg = op - 'h58; rq = "R3"; end
      else if (op >= 'h70 && op <= 'h7F) begin cls = 3; cc = op - 'h70; rq = "R4"; end
      else if (op == 'h90) begin
        rq = "R6";
        if ((pf & 2) != 0) cls = 9;
        else if ((pf & 1) != 0) cls = 8;
        else cls = 7;
      end else if (op == 'hFF) begin
        if (!mv) begin cls = 16; nm = 1; rq = "R7"; end
        else begin
          rq = "R8";
          case (r)
            0: cls = 10;
            1: cls = 11;
            2: cls = 12;
            4: cls = 13;
            6: cls = 14;
            7: cls = 15;
            default: cls = 0;
          endcase
        end
      end
    end else if (mp == 1) begin
      rq = "R5";
      if (op >= 'h40 && op <= 'h4F) begin cls = 4; cc = op - 'h40; end
      else if (op >= 'h80 && op <= 'h8F) begin cls = 5; cc = op - 'h80; end
      else if (op >= 'h90 && op <= 'h9F) begin cls = 6; cc = op - 'h90; end
      else rq = "R9";
    end
  endtask

  // Cycle-by-cycle model of the output register
  bit    m_valid = 0;
  int    m_cls, m_reg, m_cond, m_need;
  string m_req;

  always @(posedge clk) begin
    int c, g, k, n;
    string q;
    if (!rst_n) m_valid <= 0;
    else if (!m_valid || out_ready) begin
      m_valid <= in_valid;
      if (in_valid) begin
        expect_of(in_map, in_opcode, in_prefix, in_modrm_valid, in_modrm, c, g, k, n, q);
        m_cls <= c; m_reg <= g; m_cond <= k; m_need <= n; m_req <= q;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    if (rst_n && !done) begin
      check(out_valid == m_valid, "R10", "out_valid", out_valid, m_valid);
      check(in_ready == (!m_valid || out_ready), "R10", "in_ready", in_ready,
            !m_valid || out_ready);
      if (m_valid && out_valid) begin
        check(out_class == m_cls && out_reg == m_reg && out_cond == m_cond &&
              out_need_modrm == m_need, m_req, "class/reg/cond/need",
              {out_class, out_reg, out_cond, out_need_modrm},
              {m_cls[4:0], m_reg[2:0], m_cond[3:0], m_need[0]});
      end
    end
  end

  task automatic pick_ready();
    out_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
  endtask

  task automatic send(input int mp, input int op, input int pf, input bit mv, input int mr);
    @(negedge clk);
    in_map = mp[1:0]; in_opcode = op[7:0]; in_prefix = pf[2:0];
    in_modrm_valid = mv; in_modrm = mr[7:0]; in_valid = 1'b1;
    pick_ready();
    #1;
    while (!in_ready) begin
      @(negedge clk);
      pick_ready();
      #1;
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);

    // R2 R3 R4 R5 R9: every byte in every map
    for (int mp = 0; mp < 4; mp++)
      for (int op = 0; op < 256; op++)
        send(mp, op, $urandom % 8, $urandom % 2, $urandom % 256);

    // R6: nop alias under every prefix mix, and in the 0F map
    for (int pf = 0; pf < 8; pf++) begin
      send(0, 'h90, pf, 0, 0);
      send(1, 'h90, pf, 1, 'hFF);
    end

    // R7 R8: extension group with and without ModRM
    for (int r = 0; r < 8; r++) begin
      send(0, 'hFF, r, 1, 'hC2 | (r << 3));
      send(0, 'hFF, 7 - r, 0, r << 3);
    end

    // R10: random traffic under back-pressure
    bp_on = 1;
    for (int i = 0; i < 1500; i++)
      send($urandom % 4, (i % 3 == 0) ? 'hFF : $urandom % 256, $urandom % 8,
           $urandom % 2, $urandom % 256);

    @(negedge clk);
    in_valid = 1'b0;
    bp_on = 0;
    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    #3;
    check(out_valid == 0, "R10", "drained", out_valid, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule